// File: doc/BRIEF.md
# Telephony PCM Serial Port

This block is a line-side serial voice port. Once per 8 kHz frame it exchanges one voice sample with an external telephony device. It shifts a parallel transmit sample out on a serial data pin and gathers serial receive data into a parallel sample register. A sample is either an 8-bit companded code or a 16-bit two's-complement linear value. The bit timing follows either a long-frame sync or a short-frame sync. No companding arithmetic is done here: codes pass through unchanged.

The port can run as clock master. In that case it divides its system clock to make the bit clock and the frame sync, and the bit rate follows the sample format. It can also run as clock slave, taking both clocks from outside. The clock-select input is read once, in the first cycle after reset. A new value therefore needs a reset before it takes effect. In slave mode the port watches the sync line. If no sync edge arrives for several frame periods, the line is stuck and the port powers down. A mode input decides whether the last received sample is kept or cleared in that case. The port wakes at the next sync edge.

Top module: `pcm_serial_port`

## Requirements
- R1: While reset is asserted: tx_oe_o=0, clk_oe_o=0, rx_sample_o=0, rx_valid_o=0 and power_down_o=0.
- R2: slave_mode_i is captured in the first cycle after reset. When it is 0 (master), clk_oe_o=1 and bclk_o/sync_o toggle. When it is 1 (slave), clk_oe_o=0 and bclk_i/sync_i are used. Later changes have no effect until the next reset.
- R3: In master mode the bit clock period is DIV_COMP (32) system clocks for companded samples and DIV_LIN (16) for linear samples. The sync period is CLKS_PER_FRAME (256) clocks in both formats. Every sync rise coincides with a bit clock rise.
- R4: Linear format applies when fmt_pin_i=1 or fmt_bit_i=1, and a sample is then 16 bits. Otherwise a sample is 8 bits in bits [7:0]: bits [15:8] of tx_sample_i are not sent, and bits [15:8] of rx_sample_o read 0.
- R5: In long-frame mode (short_sync_i=0) a frame starts at the bit clock rise where sync is first seen high. The transmit MSB is launched at that rise, and the other bits follow MSB first, one per later rise.
- R6: In short-frame mode (short_sync_i=1) sync is high for one bit clock period. The frame starts at the rise after the one where sync was seen high, with the MSB launched at that start rise.
- R7: Receive bit i (i=0 is the MSB) is sampled at bit clock rise i+1 after the start rise. After the last bit, rx_sample_o holds the assembled word and rx_valid_o pulses for one cycle.
- R8: tx_oe_o is 1 from the start rise until the rise that follows the last sample bit, and 0 at all other times.
- R9: If sync shows no edge for STALL_FRAMES*CLKS_PER_FRAME (1024) clocks, power_down_o=1. While power_down_o=1, tx_oe_o=0 and no transfer runs.
- R10: On entry to power-down, pd_clear_i=1 clears rx_sample_o to 0, and pd_clear_i=0 keeps its value.
- R11: Power-down ends at the next sync edge, and later frames transfer normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode_i | input | 1 | 0 = clock master, 1 = clock slave (read once after reset) |
| fmt_pin_i | input | 1 | Linear format select, pin source |
| fmt_bit_i | input | 1 | Linear format select, register source |
| short_sync_i | input | 1 | 1 = short-frame sync, 0 = long-frame sync |
| pd_clear_i | input | 1 | Power-down mode: 1 clears the receive sample |
| bclk_i | input | 1 | External bit clock (slave) |
| sync_i | input | 1 | External frame sync (slave) |
| rx_data_i | input | 1 | Serial receive data |
| tx_sample_i | input | 16 | Sample to transmit |
| bclk_o | output | 1 | Generated bit clock (master) |
| sync_o | output | 1 | Generated frame sync (master) |
| clk_oe_o | output | 1 | Drive enable for the clock pins |
| tx_data_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Drive enable for transmit data |
| rx_sample_o | output | 16 | Last received sample |
| rx_valid_o | output | 1 | One-cycle pulse when a sample arrives |
| power_down_o | output | 1 | Stuck-sync power-down state |

## Verification
In master mode, tx_data_o changes one system clock after a bclk_o rise. In slave mode it changes three clocks after a bclk_i rise: two synchronizer stages and one register. rx_sample_o follows the detected final rise by one clock in the same way, and power_down_o rises about 1024 clocks after the last sync edge plus the synchronizer delay. The bench holds each slave bit clock level for four clocks and samples seven clocks after every rise, so each result has settled before it is read. It changes receive data at the falling edge. In master mode it only reads outputs after whole frames have passed, or counts clocks between pin rises.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {
    SYNC_LONG  = 1'b0,
    SYNC_SHORT = 1'b1
  } sync_fmt_e;
endpackage

// File: rtl/pcm_clkgen.sv
module pcm_clkgen #(
  parameter int CLKS_PER_FRAME = 256,
  parameter int DIV_COMP       = 32,
  parameter int DIV_LIN        = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic fmt_lin_i,
  input  logic short_sync_i,
  output logic bclk_o,
  output logic sync_o
);
  localparam int SLOTS_COMP = CLKS_PER_FRAME / DIV_COMP;
  localparam int SLOTS_LIN  = CLKS_PER_FRAME / DIV_LIN;
  localparam int DW = $clog2(DIV_COMP > DIV_LIN ? DIV_COMP : DIV_LIN);
  localparam int SW = $clog2(SLOTS_COMP > SLOTS_LIN ? SLOTS_COMP : SLOTS_LIN);

  logic [DW-1:0] div_q, div_d, div_max, half;
  logic [SW-1:0] slot_q, slot_d, slot_max;
  logic          bclk_d, sync_d, wrap;

  assign div_max  = fmt_lin_i ? DW'(DIV_LIN - 1) : DW'(DIV_COMP - 1);
  assign half     = fmt_lin_i ? DW'(DIV_LIN / 2) : DW'(DIV_COMP / 2);
  assign slot_max = fmt_lin_i ? SW'(SLOTS_LIN - 1) : SW'(SLOTS_COMP - 1);
  assign wrap     = (div_q >= div_max);

  always_comb begin
    div_d  = '0;
    slot_d = '0;
    bclk_d = 1'b0;
    sync_d = 1'b0;
    if (en_i) begin
      div_d  = wrap ? '0 : div_q + 1'b1;
      slot_d = wrap ? ((slot_q >= slot_max) ? '0 : slot_q + 1'b1) : slot_q;
      bclk_d = (div_q < half);
      sync_d = short_sync_i ? (slot_q == slot_max) : (slot_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      slot_q <= '0;
      bclk_o <= 1'b0;
      sync_o <= 1'b0;
    end else begin
      div_q  <= div_d;
      slot_q <= slot_d;
      bclk_o <= bclk_d;
      sync_o <= sync_d;
    end
  end

  // R3: generated sync only rises together with a bit clock rise
  assert_sync_on_bclk_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> $rose(bclk_o));
endmodule

// File: rtl/pcm_stall_mon.sv
module pcm_stall_mon #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_s_i,
  output logic pd_o
);
  localparam int CW = $clog2(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sync_q, pd_d, edge_seen, at_lim;

  assign edge_seen = sync_s_i ^ sync_q;
  assign at_lim    = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    pd_d  = pd_o;
    if (edge_seen) begin
      cnt_d = '0;
      pd_d  = 1'b0;
    end else if (at_lim) begin
      pd_d  = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
      pd_o   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_s_i;
      pd_o   <= pd_d;
    end
  end

  // R9: power-down is entered only in a cycle that follows a quiet sync line
  assert_pd_entry_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_o) |-> ($past(sync_s_i) == $past(sync_q)));
  // R11: power-down is left only after a sync edge
  assert_pd_exit_on_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_o) |-> ($past(sync_s_i) != $past(sync_q)));
endmodule

// File: rtl/pcm_shifter.sv
module pcm_shifter #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              sync_s_i,
  input  logic              rx_bit_i,
  input  logic              short_sync_i,
  input  logic              fmt_lin_i,
  input  logic              pd_i,
  input  logic              pd_clear_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_bit_o,
  output logic              tx_oe_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);
  import pcm_port_pkg::*;
  localparam int CNT_W = $clog2(WORD_W);

  logic              sync_last_q, sync_last_d, pend_q, pend_d;
  logic              active_q, active_d, w16_q, w16_d;
  logic              tx_bit_d, tx_oe_d, rx_valid_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sr_rx_q, sr_rx_d, sr_tx_q, sr_tx_d, rx_word_d;
  logic [WORD_W-1:0] aligned, shifted;
  logic              start, last;

  assign start   = (sync_fmt_e'(short_sync_i) == SYNC_SHORT) ? pend_q
                                                             : (sync_s_i & ~sync_last_q);
  assign last    = active_q && (cnt_q == (w16_q ? CNT_W'(WORD_W - 1) : CNT_W'(CODE_W - 1)));
  assign aligned = fmt_lin_i ? tx_word_i : (tx_word_i << (WORD_W - CODE_W));
  assign shifted = {sr_rx_q[WORD_W-2:0], rx_bit_i};

  always_comb begin
    sync_last_d = sync_last_q;
    pend_d      = pend_q;
    active_d    = active_q;
    w16_d       = w16_q;
    cnt_d       = cnt_q;
    sr_rx_d     = sr_rx_q;
    sr_tx_d     = sr_tx_q;
    tx_bit_d    = tx_bit_o;
    tx_oe_d     = tx_oe_o;
    rx_word_d   = rx_word_o;
    rx_valid_d  = 1'b0;
    if (pd_i) begin
      sync_last_d = sync_s_i;
      pend_d      = 1'b0;
      active_d    = 1'b0;
      tx_oe_d     = 1'b0;
      if (pd_clear_i) rx_word_d = '0;
    end else if (rise_i) begin
      sync_last_d = sync_s_i;
      pend_d      = short_sync_i & sync_s_i;
      if (active_q) begin
        sr_rx_d  = shifted;
        cnt_d    = cnt_q + 1'b1;
        tx_bit_d = sr_tx_q[WORD_W-1];
        sr_tx_d  = sr_tx_q << 1;
      end
      if (last) begin
        rx_word_d  = w16_q ? shifted : {{(WORD_W-CODE_W){1'b0}}, shifted[CODE_W-1:0]};
        rx_valid_d = 1'b1;
        active_d   = 1'b0;
        tx_oe_d    = 1'b0;
      end
      if (start) begin
        active_d = 1'b1;
        tx_oe_d  = 1'b1;
        cnt_d    = '0;
        w16_d    = fmt_lin_i;
        tx_bit_d = aligned[WORD_W-1];
        sr_tx_d  = aligned << 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_last_q <= 1'b0;
      pend_q      <= 1'b0;
      active_q    <= 1'b0;
      w16_q       <= 1'b0;
      cnt_q       <= '0;
      sr_rx_q     <= '0;
      sr_tx_q     <= '0;
      tx_bit_o    <= 1'b0;
      tx_oe_o     <= 1'b0;
      rx_word_o   <= '0;
      rx_valid_o  <= 1'b0;
    end else begin
      sync_last_q <= sync_last_d;
      pend_q      <= pend_d;
      active_q    <= active_d;
      w16_q       <= w16_d;
      cnt_q       <= cnt_d;
      sr_rx_q     <= sr_rx_d;
      sr_tx_q     <= sr_tx_d;
      tx_bit_o    <= tx_bit_d;
      tx_oe_o     <= tx_oe_d;
      rx_word_o   <= rx_word_d;
      rx_valid_o  <= rx_valid_d;
    end
  end

  // R9: the data driver stays off through power-down
  assert_oe_off_in_pd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_i && $past(pd_i)) |-> !tx_oe_o);
  // R5: serial data only moves right after a bit clock rise
  assert_tx_moves_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rise_i) |-> $stable(tx_bit_o));
  // R7: a completed sample is flagged for a single cycle
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int CLKS_PER_FRAME = 256,
  parameter int DIV_COMP       = 32,
  parameter int DIV_LIN        = 16,
  parameter int STALL_FRAMES   = 4,
  parameter int WORD_W         = 16,
  parameter int CODE_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode_i,
  input  logic              fmt_pin_i,
  input  logic              fmt_bit_i,
  input  logic              short_sync_i,
  input  logic              pd_clear_i,
  input  logic              bclk_i,
  input  logic              sync_i,
  input  logic              rx_data_i,
  input  logic [WORD_W-1:0] tx_sample_i,
  output logic              bclk_o,
  output logic              sync_o,
  output logic              clk_oe_o,
  output logic              tx_data_o,
  output logic              tx_oe_o,
  output logic [WORD_W-1:0] rx_sample_o,
  output logic              rx_valid_o,
  output logic              power_down_o
);
  localparam int STALL_LIMIT = STALL_FRAMES * CLKS_PER_FRAME;
  localparam int NPIN        = 3;

  logic            rst_meta_q, rst_sync_n;
  logic            cfg_done_q, slave_q;
  logic [NPIN-1:0] pin_raw, pin_s1_q, pin_s2_q;
  logic            bclk_m, sync_m, bclk_s, sync_s, bclk_prev_q, rise;
  logic            fmt_lin, gen_en;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // clock-select capture, once per reset
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_done_q <= 1'b0;
      slave_q    <= 1'b0;
    end else if (!cfg_done_q) begin
      cfg_done_q <= 1'b1;
      slave_q    <= slave_mode_i;
    end
  end

  // two-stage synchronizers for the external pins
  assign pin_raw = {rx_data_i, sync_i, bclk_i};
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pin_s1_q    <= '0;
      pin_s2_q    <= '0;
      bclk_prev_q <= 1'b0;
    end else begin
      pin_s1_q    <= pin_raw;
      pin_s2_q    <= pin_s1_q;
      bclk_prev_q <= bclk_s;
    end
  end

  assign fmt_lin  = fmt_pin_i | fmt_bit_i;
  assign gen_en   = cfg_done_q & ~slave_q;
  assign clk_oe_o = gen_en;
  assign bclk_s   = slave_q ? pin_s2_q[0] : bclk_m;
  assign sync_s   = slave_q ? pin_s2_q[1] : sync_m;
  assign rise     = bclk_s & ~bclk_prev_q;
  assign bclk_o   = bclk_m;
  assign sync_o   = sync_m;

  pcm_clkgen #(
    .CLKS_PER_FRAME(CLKS_PER_FRAME), .DIV_COMP(DIV_COMP), .DIV_LIN(DIV_LIN)
  ) clkgen_i (
    .clk(clk), .rst_n(rst_sync_n), .en_i(gen_en), .fmt_lin_i(fmt_lin),
    .short_sync_i(short_sync_i), .bclk_o(bclk_m), .sync_o(sync_m)
  );

  pcm_stall_mon #(.LIMIT(STALL_LIMIT)) stall_i (
    .clk(clk), .rst_n(rst_sync_n), .sync_s_i(sync_s), .pd_o(power_down_o)
  );

  pcm_shifter #(.WORD_W(WORD_W), .CODE_W(CODE_W)) shifter_i (
    .clk(clk), .rst_n(rst_sync_n), .rise_i(rise), .sync_s_i(sync_s),
    .rx_bit_i(pin_s2_q[2]), .short_sync_i(short_sync_i), .fmt_lin_i(fmt_lin),
    .pd_i(power_down_o), .pd_clear_i(pd_clear_i), .tx_word_i(tx_sample_i),
    .tx_bit_o(tx_data_o), .tx_oe_o(tx_oe_o), .rx_word_o(rx_sample_o),
    .rx_valid_o(rx_valid_o)
  );

  // R2: the captured clock mode holds until the next reset
  assert_mode_locked_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_done_q && $past(cfg_done_q)) |-> $stable(slave_q));
endmodule

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        slave_mode_i, fmt_pin_i, fmt_bit_i, short_sync_i, pd_clear_i;
  logic        bclk_i, sync_i, rx_drv;
  wire         rx_pin;
  logic [15:0] tx_sample_i;
  logic        bclk_o, sync_o, clk_oe_o, tx_data_o, tx_oe_o, rx_valid_o, power_down_o;
  logic [15:0] rx_sample_o;
  logic        loop_en;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  assign rx_pin = loop_en ? tx_data_o : rx_drv;

  pcm_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .slave_mode_i(slave_mode_i), .fmt_pin_i(fmt_pin_i),
    .fmt_bit_i(fmt_bit_i), .short_sync_i(short_sync_i), .pd_clear_i(pd_clear_i),
    .bclk_i(bclk_i), .sync_i(sync_i), .rx_data_i(rx_pin), .tx_sample_i(tx_sample_i),
    .bclk_o(bclk_o), .sync_o(sync_o), .clk_oe_o(clk_oe_o), .tx_data_o(tx_data_o),
    .tx_oe_o(tx_oe_o), .rx_sample_o(rx_sample_o), .rx_valid_o(rx_valid_o),
    .power_down_o(power_down_o)
  );

  // {slave, linear, short, tx word, rx word}
  localparam logic [34:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 16'h7EA5, 16'h0000},
    {1'b0, 1'b1, 1'b1, 16'h8F31, 16'h0000},
    {1'b1, 1'b0, 1'b0, 16'h7E3C, 16'hFFC9},
    {1'b1, 1'b0, 1'b1, 16'h0081, 16'h337E},
    {1'b1, 1'b1, 1'b0, 16'h1234, 16'hBEEF},
    {1'b1, 1'b1, 1'b1, 16'hF00D, 16'h5A5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic sl, input logic lin, input logic use_bit, input logic sh);
    @(negedge clk);
    rst_n = 1'b0;
    slave_mode_i = sl;
    fmt_pin_i = lin & ~use_bit;
    fmt_bit_i = lin & use_bit;
    short_sync_i = sh;
    loop_en = ~sl;
    bclk_i = 1'b0;
    sync_i = 1'b0;
    rx_drv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one slave frame: 32 bit periods of 8 clocks, data changed at the falling edge
  task automatic slave_frame(input logic lin, input logic sh, input logic [15:0] rxw,
                             output logic [15:0] cap, output logic oe_first,
                             output logic oe_after);
    int n = lin ? 16 : 8;
    cap = '0;
    oe_first = 1'b0;
    oe_after = 1'b1;
    for (int s = 0; s < 32; s++) begin
      bclk_i = 1'b1;
      sync_i = sh ? (s == 31) : (s == 0);
      repeat (4) @(negedge clk);
      bclk_i = 1'b0;
      rx_drv = (s < n) ? rxw[n-1-s] : 1'b0;
      repeat (3) @(negedge clk);
      if (s < n) cap[n-1-s] = tx_data_o;
      if (s == 0) oe_first = tx_oe_o;
      if (s == n + 1) oe_after = tx_oe_o;
      @(negedge clk);
    end
  endtask

  task automatic period_of(input bit use_sync, output int n);
    logic prev, cur;
    prev = 1'b1;
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      cur = use_sync ? sync_o : bclk_o;
      if (cur && !prev) break;
      prev = cur;
    end
    prev = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      n++;
      cur = use_sync ? sync_o : bclk_o;
      if (cur && !prev) break;
      prev = cur;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] cap, exp_tx, exp_rx;
    logic        o1, o2;
    int          per, rises;
    logic        prev;
    rst_n = 1'b0;
    slave_mode_i = 1'b0; fmt_pin_i = 1'b0; fmt_bit_i = 1'b0; short_sync_i = 1'b0;
    pd_clear_i = 1'b0; bclk_i = 1'b0; sync_i = 1'b0; rx_drv = 1'b0; loop_en = 1'b0;
    tx_sample_i = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1 tx_oe in reset", 32'(tx_oe_o), 32'd0);
    chk("R1 clk_oe in reset", 32'(clk_oe_o), 32'd0);
    chk("R1 rx_sample in reset", 32'(rx_sample_o), 32'd0);
    chk("R1 power_down in reset", 32'(power_down_o), 32'd0);
    chk("R1 rx_valid in reset", 32'(rx_valid_o), 32'd0);

    for (int i = 0; i < 6; i++) begin
      logic vs, vl, vsh;
      logic [15:0] vtx, vrx;
      {vs, vl, vsh, vtx, vrx} = VEC[i];
      tx_sample_i = vtx;
      do_reset(vs, vl, i[0], vsh);
      exp_tx = vl ? vtx : {8'h00, vtx[7:0]};
      exp_rx = vl ? vrx : {8'h00, vrx[7:0]};
      if (!vs) begin
        repeat (1200) @(negedge clk);
        chk("R7 R4 master loopback sample", 32'(rx_sample_o), 32'(exp_tx));
        chk("R2 master drives clocks", 32'(clk_oe_o), 32'd1);
        period_of(1'b0, per);
        chk("R3 bit clock period", per, vl ? 16 : 32);
        period_of(1'b1, per);
        chk("R3 sync period", per, 256);
      end else begin
        repeat (3) slave_frame(vl, vsh, vrx, cap, o1, o2);
        slave_frame(vl, vsh, vrx, cap, o1, o2);
        chk("R7 R4 slave rx sample", 32'(rx_sample_o), 32'(exp_rx));
        if (vsh) chk("R6 short-frame tx word", 32'(cap), 32'(exp_tx));
        else     chk("R5 long-frame tx word", 32'(cap), 32'(exp_tx));
        chk("R8 tx_oe during first bit", 32'(o1), 32'd1);
        chk("R8 tx_oe after last bit", 32'(o2), 32'd0);
        chk("R2 slave leaves clocks undriven", 32'(clk_oe_o), 32'd0);
      end
    end

    // R2: clock select change after reset has no effect
    do_reset(1'b0, 1'b0, 1'b0, 1'b0);
    slave_mode_i = 1'b1;
    rises = 0;
    prev = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (bclk_o && !prev) rises++;
      prev = bclk_o;
    end
    chk("R2 mode held after late change", 32'(clk_oe_o), 32'd1);
    chk("R2 bit clock still running", 32'(rises > 5), 32'd1);
    do_reset(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 new mode after reset", 32'(clk_oe_o), 32'd0);

    // R9 R10 R11: stuck sync handling
    tx_sample_i = 16'h0055;
    pd_clear_i = 1'b0;
    repeat (2) slave_frame(1'b0, 1'b0, 16'h00A7, cap, o1, o2);
    chk("R7 rx before stall", 32'(rx_sample_o), 32'h00A7);
    sync_i = 1'b1;
    bclk_i = 1'b0;
    repeat (1100) @(negedge clk);
    chk("R9 power-down on stuck high sync", 32'(power_down_o), 32'd1);
    chk("R9 tx_oe off in power-down", 32'(tx_oe_o), 32'd0);
    chk("R10 sample kept when pd_clear=0", 32'(rx_sample_o), 32'h00A7);
    repeat (2) slave_frame(1'b0, 1'b0, 16'h0042, cap, o1, o2);
    chk("R11 power-down left at sync edge", 32'(power_down_o), 32'd0);
    chk("R11 transfer after wake", 32'(rx_sample_o), 32'h0042);
    chk("R11 tx word after wake", 32'(cap), 32'h0055);
    pd_clear_i = 1'b1;
    sync_i = 1'b0;
    repeat (1100) @(negedge clk);
    chk("R9 power-down on stuck low sync", 32'(power_down_o), 32'd1);
    chk("R10 sample cleared when pd_clear=1", 32'(rx_sample_o), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule